// File: doc/BRIEF.md
# SRAM write timing checker

This block watches the bus of an asynchronous static RAM on a fast sampling clock and judges every write cycle against the minimum timing rules of one of two speed grades. It needs no help from the memory controller. Each clock edge takes one sample of the chip-enable and write-enable strobes, the address and the data, and all intervals are counted in whole samples. With the default 5 ns clock, every nanosecond limit is rounded up to the next whole sample.

A write is the overlap of the two strobes, both low. It begins on the sample where the later of the two strobes has fallen. It ends on the first sample after the overlap where either strobe is high again. Each check runs at the moment where its interval closes. The rules are: overlap width, chip-enable and address lead time up to the end, data setup before the end, start-to-start cycle time, recovery and hold after the end, and address stability inside the overlap.

A failing check produces a one-cycle violation pulse and sets a sticky flag. It also stores a 3-bit code that names the first failed rule, and the code stays until reset. A write-seen pulse marks every completed write.

Top module: `sram_wr_timing_chk`

## Requirements
- R1: After reset every output is 0. Code 0 means that no violation has occurred.
- R2: `write_seen_o` is high for exactly the one clock cycle that follows the sampling edge of the end sample. The end sample is the first sample with `ce_n_i` or `we_n_i` high after one or more samples with both low.
- R3: Code 1 is raised on the end sample when the write had fewer overlap samples than 13 (grade 0) or 17 (grade 1).
- R4: Code 2 is raised on the end sample in either of two cases: fewer consecutive samples with `ce_n_i` low before the end sample than 15 (grade 0) or 20 (grade 1), or fewer samples before the end sample carrying the final address than that same limit.
- R5: Code 3 is raised on the end sample when the data value seen on the sample before the end was held for fewer samples than 7 (grade 0) or 9 (grade 1).
- R6: Code 4 is raised on a start sample when fewer than 17 (grade 0) or 24 (grade 1) samples have passed since the previous start sample. The first write after reset is never checked for this.
- R7: Code 5 covers recovery and hold. If `we_n_i` is high on the end sample, whether alone or together with `ce_n_i`, the write address must still be present on the end sample. If only `ce_n_i` is high, the address must stay for the end sample and the 2 samples after it, and the data must stay for the end sample and the 1 sample after it.
- R8: Code 6 is raised when the address differs between two consecutive overlap samples.
- R9: When several rules fail on the same sample, the lowest code is reported. `viol_flag_o` stays high until reset. `viol_code_o` keeps the code of the first violation until reset.
- R10: `viol_pulse_o` is high for one clock cycle after each sample on which any rule fails, including violations that come after the first.
- R11: `grade_i` = 0 selects the fast limits and `grade_i` = 1 selects the slow limits of R3 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock, one sample per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| grade_i | input | 1 | Speed grade select: 0 fast, 1 slow |
| ce_n_i | input | 1 | Sampled chip enable, active low |
| we_n_i | input | 1 | Sampled write enable, active low |
| addr_i | input | AW | Sampled address bus |
| data_i | input | DW | Sampled data bus |
| write_seen_o | output | 1 | One-cycle pulse for each completed write |
| viol_pulse_o | output | 1 | One-cycle pulse for each detected violation |
| viol_flag_o | output | 1 | Sticky violation flag |
| viol_code_o | output | 3 | Code of the first violation, 1 to 6 |

## Verification
The properties assume that the strobes, address and data are already synchronous to the sampling clock, so each rising edge sees one settled sample. They also assume that the grade select does not move during a write. The stimulus follows both assumptions. It changes the bus only one nanosecond after a rising edge, drives one value per clock, and holds the grade steady inside each scenario. Every scenario starts from a fresh reset, so the sticky code shows the first rule that the scenario breaks.

// File: rtl/swc_pkg.sv
`timescale 1ns/1ps
package swc_pkg;

    // Width of the sample counters and of every limit.
    localparam int LIM_W  = 8;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CODE_NONE    = 3'd0,
        CODE_PULSE   = 3'd1,
        CODE_LEAD    = 3'd2,
        CODE_SETUP   = 3'd3,
        CODE_CYCLE   = 3'd4,
        CODE_RECOVER = 3'd5,
        CODE_ADDRMOV = 3'd6
    } viol_e;

    // Limits in nanoseconds for both grades.
    localparam int FAST_PULSE_NS = 65;
    localparam int SLOW_PULSE_NS = 85;
    localparam int FAST_LEAD_NS  = 75;
    localparam int SLOW_LEAD_NS  = 100;
    localparam int FAST_SETUP_NS = 35;
    localparam int SLOW_SETUP_NS = 45;
    localparam int FAST_CYCLE_NS = 85;
    localparam int SLOW_CYCLE_NS = 120;
    // Recovery and hold pairs; they are the same for both grades.
    localparam int WE_REC_NS  = 5;
    localparam int WE_HOLD_NS = 0;
    localparam int CE_REC_NS  = 15;
    localparam int CE_HOLD_NS = 10;

    // Converts a nanosecond limit to whole samples, rounding up.
    function automatic logic [LIM_W-1:0] to_samples(input int ns, input int per_ns);
        int s;
        s = (ns + per_ns - 1) / per_ns;
        return s[LIM_W-1:0];
    endfunction

    typedef struct packed {
        logic [LIM_W-1:0] pulse;
        logic [LIM_W-1:0] lead;
        logic [LIM_W-1:0] setup;
        logic [LIM_W-1:0] cycle;
        logic [LIM_W-1:0] rec_we;
        logic [LIM_W-1:0] hold_we;
        logic [LIM_W-1:0] rec_ce;
        logic [LIM_W-1:0] hold_ce;
    } limits_t;

endpackage

// File: rtl/swc_limits.sv
`timescale 1ns/1ps
module swc_limits
    import swc_pkg::*;
#(
    parameter int SAMPLE_NS = 5
) (
    input  logic    grade_i,
    output limits_t lim_o
);
    localparam limits_t FAST_LIM = '{
        pulse:   to_samples(FAST_PULSE_NS, SAMPLE_NS),
        lead:    to_samples(FAST_LEAD_NS,  SAMPLE_NS),
        setup:   to_samples(FAST_SETUP_NS, SAMPLE_NS),
        cycle:   to_samples(FAST_CYCLE_NS, SAMPLE_NS),
        rec_we:  to_samples(WE_REC_NS,     SAMPLE_NS),
        hold_we: to_samples(WE_HOLD_NS,    SAMPLE_NS),
        rec_ce:  to_samples(CE_REC_NS,     SAMPLE_NS),
        hold_ce: to_samples(CE_HOLD_NS,    SAMPLE_NS)
    };
    localparam limits_t SLOW_LIM = '{
        pulse:   to_samples(SLOW_PULSE_NS, SAMPLE_NS),
        lead:    to_samples(SLOW_LEAD_NS,  SAMPLE_NS),
        setup:   to_samples(SLOW_SETUP_NS, SAMPLE_NS),
        cycle:   to_samples(SLOW_CYCLE_NS, SAMPLE_NS),
        rec_we:  to_samples(WE_REC_NS,     SAMPLE_NS),
        hold_we: to_samples(WE_HOLD_NS,    SAMPLE_NS),
        rec_ce:  to_samples(CE_REC_NS,     SAMPLE_NS),
        hold_ce: to_samples(CE_HOLD_NS,    SAMPLE_NS)
    };

    assign lim_o = grade_i ? SLOW_LIM : FAST_LIM;
endmodule

// File: rtl/swc_run_ctr.sv
`timescale 1ns/1ps
// Saturating run-length counter. It counts up while cont_i is high and
// otherwise reloads RESTART.
module swc_run_ctr #(
    parameter int W       = 8,
    parameter int RESTART = 0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         cont_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP_VAL  = '1;
    localparam logic [W-1:0] LOAD_VAL = W'(RESTART);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = LOAD_VAL;
        if (cont_i) begin
            cnt_d = (cnt_q == TOP_VAL) ? cnt_q : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/swc_recov_mon.sv
`timescale 1ns/1ps
// Watches the samples from the end sample onwards and checks that the
// write address and data stay for the recovery and hold counts chosen there.
module swc_recov_mon
    import swc_pkg::*;
#(
    parameter int AW = 17,
    parameter int DW = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wend_i,
    input  logic [LIM_W-1:0] rec_i,
    input  logic [LIM_W-1:0] hold_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    data_i,
    input  logic [AW-1:0]    addr_ref_i,
    input  logic [DW-1:0]    data_ref_i,
    output logic             fail_o
);
    localparam logic [LIM_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic             watch;
        logic             a_ok;
        logic             d_ok;
        logic [LIM_W-1:0] a_cnt;
        logic [LIM_W-1:0] d_cnt;
        logic [LIM_W-1:0] rec;
        logic [LIM_W-1:0] hold;
        logic [AW-1:0]    a_ref;
        logic [DW-1:0]    d_ref;
    } mon_t;

    mon_t s_d, s_q, base;
    logic a_same, d_same, watching, done;

    always_comb begin
        base = s_q;
        if (wend_i) begin
            base.a_ok  = 1'b1;
            base.d_ok  = 1'b1;
            base.a_cnt = '0;
            base.d_cnt = '0;
            base.rec   = rec_i;
            base.hold  = hold_i;
            base.a_ref = addr_ref_i;
            base.d_ref = data_ref_i;
        end

        a_same   = base.a_ok && (addr_i == base.a_ref);
        d_same   = base.d_ok && (data_i == base.d_ref);
        watching = wend_i || s_q.watch;

        s_d      = base;
        s_d.a_ok = a_same;
        s_d.d_ok = d_same;
        if (a_same && base.a_cnt != CNT_TOP) s_d.a_cnt = base.a_cnt + 1'b1;
        if (d_same && base.d_cnt != CNT_TOP) s_d.d_cnt = base.d_cnt + 1'b1;

        fail_o = watching &&
                 ((!a_same && s_d.a_cnt < base.rec) ||
                  (!d_same && s_d.d_cnt < base.hold));
        done   = (s_d.a_cnt >= base.rec) && (s_d.d_cnt >= base.hold);
        s_d.watch = watching && !fail_o && !done;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end
endmodule

// File: rtl/sram_wr_timing_chk.sv
`timescale 1ns/1ps
module sram_wr_timing_chk
    import swc_pkg::*;
#(
    parameter int AW        = 17,
    parameter int DW        = 16,
    parameter int SAMPLE_NS = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          grade_i,
    input  logic          ce_n_i,
    input  logic          we_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          write_seen_o,
    output logic          viol_pulse_o,
    output logic          viol_flag_o,
    output logic [2:0]    viol_code_o
);
    // Run counters, one per measured interval.
    localparam int RUN_ACT   = 0;  // overlap samples
    localparam int RUN_CE    = 1;  // chip-enable low samples
    localparam int RUN_ADDR  = 2;  // samples carrying the present address
    localparam int RUN_DATA  = 3;  // samples carrying the present data
    localparam int RUN_SINCE = 4;  // samples since the last start
    localparam int NRUN      = 5;

    typedef struct packed {
        logic          act;
        logic          started;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          wseen;
        logic          vpulse;
        logic          flag;
        viol_e         code;
    } state_t;

    state_t  s_d, s_q;
    limits_t lim;

    logic             active, wr_start, wr_end;
    logic [NRUN-1:0]  run_cont;
    logic [LIM_W-1:0] run_cnt [NRUN];
    logic [LIM_W-1:0] rec_sel, hold_sel;
    logic             recov_fail;
    logic             bad_pulse, bad_lead, bad_setup, bad_cycle, bad_move;
    viol_e            sel;

    assign active   = !ce_n_i && !we_n_i;
    assign wr_start = active && !s_q.act;
    assign wr_end   = !active && s_q.act;

    swc_limits #(.SAMPLE_NS(SAMPLE_NS)) i_limits (
        .grade_i (grade_i),
        .lim_o   (lim)
    );

    assign run_cont[RUN_ACT]   = active;
    assign run_cont[RUN_CE]    = !ce_n_i;
    assign run_cont[RUN_ADDR]  = (addr_i == s_q.addr);
    assign run_cont[RUN_DATA]  = (data_i == s_q.data);
    assign run_cont[RUN_SINCE] = !wr_start;

    for (genvar g = 0; g < NRUN; g++) begin : g_run
        localparam int RESTART_V =
            (g == RUN_ADDR || g == RUN_DATA || g == RUN_SINCE) ? 1 : 0;
        swc_run_ctr #(.W(LIM_W), .RESTART(RESTART_V)) i_run (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cont_i (run_cont[g]),
            .cnt_o  (run_cnt[g])
        );
    end

    // The looser pair applies whenever write enable is high on the end sample.
    assign rec_sel  = we_n_i ? lim.rec_we  : lim.rec_ce;
    assign hold_sel = we_n_i ? lim.hold_we : lim.hold_ce;

    swc_recov_mon #(.AW(AW), .DW(DW)) i_recov (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wend_i     (wr_end),
        .rec_i      (rec_sel),
        .hold_i     (hold_sel),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .addr_ref_i (s_q.addr),
        .data_ref_i (s_q.data),
        .fail_o     (recov_fail)
    );

    // Counters hold values through the previous sample.
    assign bad_pulse = wr_end && (run_cnt[RUN_ACT] < lim.pulse);
    assign bad_lead  = wr_end && ((run_cnt[RUN_CE] < lim.lead) ||
                                  (run_cnt[RUN_ADDR] < lim.lead));
    assign bad_setup = wr_end && (run_cnt[RUN_DATA] < lim.setup);
    assign bad_cycle = wr_start && s_q.started &&
                       (run_cnt[RUN_SINCE] < lim.cycle);
    assign bad_move  = active && s_q.act && (addr_i != s_q.addr);

    always_comb begin
        // Lowest code wins: assign in reverse order of priority.
        sel = CODE_NONE;
        if (bad_move)   sel = CODE_ADDRMOV;
        if (recov_fail) sel = CODE_RECOVER;
        if (bad_cycle)  sel = CODE_CYCLE;
        if (bad_setup)  sel = CODE_SETUP;
        if (bad_lead)   sel = CODE_LEAD;
        if (bad_pulse)  sel = CODE_PULSE;

        s_d         = s_q;
        s_d.act     = active;
        s_d.started = s_q.started || wr_start;
        s_d.addr    = addr_i;
        s_d.data    = data_i;
        s_d.wseen   = wr_end;
        s_d.vpulse  = (sel != CODE_NONE);
        s_d.flag    = s_q.flag || (sel != CODE_NONE);
        if (!s_q.flag) s_d.code = sel;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign write_seen_o = s_q.wseen;
    assign viol_pulse_o = s_q.vpulse;
    assign viol_flag_o  = s_q.flag;
    assign viol_code_o  = s_q.code;
endmodule

// File: rtl/swc_chk.sv
`timescale 1ns/1ps
module swc_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       ce_n_i,
    input logic       we_n_i,
    input logic       write_seen_o,
    input logic       viol_pulse_o,
    input logic       viol_flag_o,
    input logic [2:0] viol_code_o
);
    a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_flag_o |=> viol_flag_o);

    a_r9_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_flag_o |=> $stable(viol_code_o));

    a_r9_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_flag_o |-> (viol_code_o != 3'd0 && viol_code_o <= 3'd6));

    a_r10_pulse_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_pulse_o |-> viol_flag_o);

    a_r10_flag_rise_pulsed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(viol_flag_o) |-> viol_pulse_o);

    a_r1_code_zero_unflagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !viol_flag_o |-> (viol_code_o == 3'd0));

    a_r2_seen_after_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        write_seen_o |-> ($past(ce_n_i || we_n_i) && $past(!ce_n_i && !we_n_i, 2)));
endmodule

bind sram_wr_timing_chk swc_chk i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ce_n_i       (ce_n_i),
    .we_n_i       (we_n_i),
    .write_seen_o (write_seen_o),
    .viol_pulse_o (viol_pulse_o),
    .viol_flag_o  (viol_flag_o),
    .viol_code_o  (viol_code_o)
);

// File: tb/test_sram_wr_timing_chk.sv
`timescale 1ns/1ps
module test_sram_wr_timing_chk;
    localparam int CLK_NS = 5;
    localparam int AW = 17;
    localparam int DW = 16;
    localparam int EM_WE = 0, EM_CE = 1, EM_BOTH = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          grade = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          write_seen, viol_pulse, viol_flag;
    logic [2:0]    viol_code;

    int n_chk = 0, n_fail = 0;
    logic ws_end, vp_end;

    always #(CLK_NS/2.0) clk = ~clk;

    sram_wr_timing_chk #(.AW(AW), .DW(DW), .SAMPLE_NS(CLK_NS)) i_sram_wr_timing_chk (
        .clk_i(clk), .rst_ni(rst_n), .grade_i(grade), .ce_n_i(ce_n), .we_n_i(we_n),
        .addr_i(addr), .data_i(data), .write_seen_o(write_seen),
        .viol_pulse_o(viol_pulse), .viol_flag_o(viol_flag), .viol_code_o(viol_code)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One sample: drive, let the edge take it, settle just after.
    task automatic drive(input logic c, input logic w, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
        ce_n = c; we_n = w; addr = a; data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b1, addr, data);
    endtask

    task automatic do_reset(input logic g);
        rst_n = 1'b0; grade = g; ce_n = 1'b1; we_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        idle(1);
    endtask

    // cel: chip-enable-low samples before the overlap; aset: samples before
    // the overlap that carry the new address; wp: overlap samples; ds: samples
    // before the end that carry the final data; emode: strobe that ends the
    // write; pa/pd: samples from the end sample on that keep address/data;
    // post: samples driven from the end sample on; amid: overlap index at
    // which the address moves (0 = never).
    task automatic wr(input int cel, input int aset, input int wp, input int ds,
                      input int emode, input int pa, input int pd, input int post,
                      input int amid);
        logic [AW-1:0] a_old, a_new, a_cur;
        logic [DW-1:0] d_old, d_new, d_cur;
        int p;
        p     = ((cel > aset) ? cel : aset) + 1;
        a_old = addr;
        a_new = addr + 17'd16;
        d_new = data + 16'd3;
        d_old = d_new ^ 16'h1;
        for (int i = p - 1; i >= 0; i--) begin
            int te;
            te = wp + i + 1;
            drive((i < cel) ? 1'b0 : 1'b1, 1'b1, (te <= aset + wp) ? a_new : a_old,
                  (te <= ds) ? d_new : d_old);
        end
        a_cur = a_new;
        for (int k = 0; k < wp; k++) begin
            if (amid > 0 && k >= amid) a_cur = a_new ^ 17'h1;
            drive(1'b0, 1'b0, a_cur, ((wp - k) <= ds) ? d_new : d_old);
        end
        d_cur = data;
        for (int j = 0; j < post; j++) begin
            logic c, w;
            c = 1'b1; w = 1'b1;
            if (j == 0) begin
                c = (emode != EM_WE);
                w = (emode != EM_CE);
            end
            drive(c, w, (j < pa) ? a_cur : (a_cur ^ 17'h2), (j < pd) ? d_cur : ~d_cur);
            if (j == 0) begin ws_end = write_seen; vp_end = viol_pulse; end
        end
    endtask

    task automatic expect_code(input string tag, input int exp);
        idle(3);
        check({tag, " flag"}, int'(viol_flag), (exp != 0) ? 1 : 0);
        check({tag, " code"}, int'(viol_code), exp);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        check("R1 write_seen", int'(write_seen), 0);
        check("R1 pulse", int'(viol_pulse), 0);
        check("R1 flag", int'(viol_flag), 0);
        check("R1 code", int'(viol_code), 0);
    endtask

    task automatic t_good();
        do_reset(1'b0);
        wr(3, 3, 13, 7, EM_WE, 1, 0, 1, 0);
        check("R2 seen at end", int'(ws_end), 1);
        idle(1);
        check("R2 seen one cycle", int'(write_seen), 0);
        expect_code("R3 R4 R5 limits met", 0);
    endtask

    task automatic t_pulse();
        do_reset(1'b0);
        wr(3, 3, 12, 7, EM_WE, 1, 0, 1, 0);
        check("R10 pulse at end", int'(vp_end), 1);
        idle(1);
        check("R10 pulse one cycle", int'(viol_pulse), 0);
        check("R9 flag sticky", int'(viol_flag), 1);
        expect_code("R3 short overlap", 1);
    endtask

    task automatic t_lead();
        do_reset(1'b0);
        wr(1, 3, 13, 7, EM_WE, 1, 0, 1, 0);
        expect_code("R4 short ce lead", 2);
        do_reset(1'b0);
        wr(3, 1, 13, 7, EM_WE, 1, 0, 1, 0);
        expect_code("R4 short address lead", 2);
    endtask

    task automatic t_setup();
        do_reset(1'b0);
        wr(3, 3, 13, 6, EM_WE, 1, 0, 1, 0);
        expect_code("R5 short data setup", 3);
    endtask

    task automatic t_cycle();
        do_reset(1'b0);
        wr(3, 3, 13, 7, EM_WE, 1, 0, 1, 0);
        wr(2, 2, 13, 7, EM_WE, 1, 0, 1, 0);   // start-to-start 17
        check("R6 cycle at limit", int'(viol_flag), 0);
        wr(1, 1, 13, 7, EM_WE, 1, 0, 1, 0);   // start-to-start 16, then code 2
        expect_code("R6 R9 short cycle first", 4);
    endtask

    task automatic t_recover();
        do_reset(1'b0);
        wr(3, 3, 13, 7, EM_WE, 0, 0, 2, 0);
        expect_code("R7 we-ended no recovery", 5);
        do_reset(1'b0);
        wr(3, 3, 13, 7, EM_CE, 3, 2, 3, 0);
        expect_code("R7 ce-ended pair met", 0);
        do_reset(1'b0);
        wr(3, 3, 13, 7, EM_CE, 2, 2, 3, 0);
        expect_code("R7 ce-ended address short", 5);
        do_reset(1'b0);
        wr(3, 3, 13, 7, EM_CE, 3, 1, 3, 0);
        expect_code("R7 ce-ended data short", 5);
        do_reset(1'b0);
        wr(3, 3, 13, 7, EM_BOTH, 1, 0, 2, 0);
        expect_code("R7 both rise loose pair", 0);
    endtask

    task automatic t_move();
        do_reset(1'b0);
        wr(3, 3, 13, 7, EM_WE, 1, 0, 1, 5);
        expect_code("R8 address moved in overlap", 6);
    endtask

    task automatic t_grade();
        do_reset(1'b1);
        wr(7, 7, 16, 9, EM_WE, 1, 0, 1, 0);
        expect_code("R11 slow short overlap", 1);
        do_reset(1'b1);
        wr(7, 7, 17, 9, EM_WE, 1, 0, 1, 0);
        expect_code("R11 slow limits met", 0);
    endtask

    task automatic t_priority();
        do_reset(1'b0);
        wr(3, 3, 12, 5, EM_WE, 1, 0, 1, 0);
        expect_code("R9 lowest code wins", 1);
    endtask

    logic finished = 1'b0;

    initial begin
        t_reset();
        t_good();
        t_pulse();
        t_lead();
        t_setup();
        t_cycle();
        t_recover();
        t_move();
        t_grade();
        t_priority();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule